// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms byte addresses for a core's load and store accesses. It holds two register classes. The index class has four base registers, each paired with a modify register. The pointer class has eight registers. Each request names a base register and a modifier source, and it selects one of two modes. In post-modify mode the block emits the base value as it stands and writes the modified value back. In offset mode it emits the base plus the modifier and leaves the register untouched. The access size sets the automatic step, so a pointer walks through memory aligned to the data width.

A software write port loads any register directly. A request whose modifier is illegal for its register class is refused. The block then raises an error strobe for one cycle and changes no state. Address and strobes are registered, so each result appears in the cycle after its request.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset every index, modify and pointer register reads as zero, and `addr_vld_o` and `err_o` are low.
- R2: An accepted request (`req_valid` high, not refused) makes `addr_vld_o` high with its address on `addr_o` in the next cycle only. `addr_vld_o` is low in any cycle that follows a cycle without an accepted request.
- R3: In post-modify mode (`req_mode`=0) the emitted address is the base register's value before the request, and the base register then holds base plus modifier.
- R4: In offset mode (`req_mode`=1) the emitted address is base plus modifier, and the base register keeps its value.
- R5: The `req_msrc` code selects the modifier: 0 adds a step and 1 subtracts it. The step is 1 for `req_size`=0 (byte), 2 for `req_size`=1 (halfword) and 4 for `req_size` 2 or 3 (word).
- R6: For the index class (`req_cls`=0), `req_msrc`=3 uses the modify register chosen by the low two bits of `req_mreg`. `req_msrc`=2 uses the sign-extended `req_imm`, which must be +2, -2, +4 or -4. The base register is chosen by the low two bits of `req_reg`.
- R7: For the pointer class (`req_cls`=1), `req_msrc`=2 uses any sign-extended 8-bit `req_imm`, and `req_msrc`=3 uses the pointer register chosen by `req_mreg`.
- R8: An index-class request with `req_msrc`=2 and an immediate outside {+2,-2,+4,-4} raises `err_o` in the next cycle and leaves `addr_vld_o` low. No register changes.
- R9: Address arithmetic wraps modulo 2^32 in both directions.
- R10: When a software write and a post-modify update target the same register in one cycle, the register takes the software data.
- R11: Back-to-back requests on the same register see the value written back by the previous request.
- R12: `wr_file` selects the target of a software write: 0 index, 1 modify, 2 pointer. Code 3 changes no register. A written value is seen by a request in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address request present |
| req_cls | input | 1 | Register class: 0 index, 1 pointer |
| req_mode | input | 1 | 0 post-modify, 1 offset without writeback |
| req_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| req_msrc | input | 2 | Modifier: 0 +step, 1 -step, 2 immediate, 3 register |
| req_reg | input | 3 | Base register select |
| req_mreg | input | 3 | Modifier register select |
| req_imm | input | 8 | Signed immediate modifier |
| wr_en | input | 1 | Software register write |
| wr_file | input | 2 | Write target file: 0 index, 1 modify, 2 pointer, 3 none |
| wr_sel | input | 3 | Write register select |
| wr_data | input | 32 | Write data |
| addr_o | output | 32 | Generated byte address |
| addr_vld_o | output | 1 | Address valid strobe |
| err_o | output | 1 | Request refused strobe |

## Verification
On every cycle the assertions check four things. A valid or error strobe appears only after a matching request. The two strobes never coincide. A post-modify address equals the base value read one cycle earlier. The automatic step is always 1, 2 or 4. They also check that an offset-mode access leaves its base register unchanged, and that a software write lands over a concurrent update.

Several outcomes show only in the bench's directed scenarios. These include the writeback values, the modulo-2^32 wrap, back-to-back chaining and the refusal of bad immediates. The bench reads each register back through an offset-mode request with a zero modifier.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic {CLS_IDX = 1'b0, CLS_PTR = 1'b1} agu_cls_e;
  typedef enum logic {MODE_POST = 1'b0, MODE_OFFS = 1'b1} agu_mode_e;
  typedef enum logic [1:0] {MSRC_INC = 2'd0, MSRC_DEC = 2'd1, MSRC_IMM = 2'd2, MSRC_REG = 2'd3} agu_msrc_e;
  typedef enum logic [1:0] {WF_IDX = 2'd0, WF_MOD = 2'd1, WF_PTR = 2'd2, WF_NONE = 2'd3} agu_wfile_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile import agu_pkg::*; #(
  parameter int AW   = 32,
  parameter int NIDX = 4,
  parameter int NPTR = 8,
  localparam int IDX_SW = $clog2(NIDX),
  localparam int PTR_SW = $clog2(NPTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_file,
  input  logic [PTR_SW-1:0] wr_sel,
  input  logic [AW-1:0]     wr_data,
  input  logic              upd_en,
  input  logic              upd_cls,
  input  logic [PTR_SW-1:0] upd_sel,
  input  logic [AW-1:0]     upd_val,
  input  logic              rd_cls,
  input  logic [PTR_SW-1:0] rd_base_sel,
  input  logic [PTR_SW-1:0] rd_mod_sel,
  output logic [AW-1:0]     base_val,
  output logic [AW-1:0]     mreg_val
);
  logic [AW-1:0] idx_q [NIDX];
  logic [AW-1:0] mod_q [NIDX];
  logic [AW-1:0] ptr_q [NPTR];

  for (genvar gi = 0; gi < NIDX; gi++) begin : g_idx
    logic          sw_hit, up_hit, en;
    logic [AW-1:0] nxt, q, mq;
    logic          msw_hit;
    always_comb begin
      sw_hit  = wr_en && (wr_file == WF_IDX) && (wr_sel[IDX_SW-1:0] == IDX_SW'(gi));
      msw_hit = wr_en && (wr_file == WF_MOD) && (wr_sel[IDX_SW-1:0] == IDX_SW'(gi));
      up_hit  = upd_en && (upd_cls == CLS_IDX) && (upd_sel[IDX_SW-1:0] == IDX_SW'(gi));
      en      = sw_hit || up_hit;
      nxt     = sw_hit ? wr_data : upd_val;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (en) q <= nxt;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mq <= '0;
      else if (msw_hit) mq <= wr_data;
    end
    assign idx_q[gi] = q;
    assign mod_q[gi] = mq;

    p_sw_wins_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sw_hit |=> (q == $past(wr_data)));
  end

  for (genvar gp = 0; gp < NPTR; gp++) begin : g_ptr
    logic          sw_hit, up_hit, en;
    logic [AW-1:0] nxt, q;
    always_comb begin
      sw_hit = wr_en && (wr_file == WF_PTR) && (wr_sel == PTR_SW'(gp));
      up_hit = upd_en && (upd_cls == CLS_PTR) && (upd_sel == PTR_SW'(gp));
      en     = sw_hit || up_hit;
      nxt    = sw_hit ? wr_data : upd_val;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (en) q <= nxt;
    end
    assign ptr_q[gp] = q;

    p_sw_wins_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sw_hit |=> (q == $past(wr_data)));
  end

  always_comb begin
    if (rd_cls == CLS_PTR) begin
      base_val = ptr_q[rd_base_sel];
      mreg_val = ptr_q[rd_mod_sel];
    end else begin
      base_val = idx_q[rd_base_sel[IDX_SW-1:0]];
      mreg_val = mod_q[rd_mod_sel[IDX_SW-1:0]];
    end
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc import agu_pkg::*; #(
  parameter int AW    = 32,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_cls,
  input  logic             req_mode,
  input  logic [1:0]       req_size,
  input  logic [1:0]       req_msrc,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [AW-1:0]    base_val,
  input  logic [AW-1:0]    mreg_val,
  output logic [AW-1:0]    addr_nxt,
  output logic             upd_en,
  output logic [AW-1:0]    upd_val,
  output logic             bad
);
  localparam logic [AW-1:0] NEG2 = ~AW'(1);
  localparam logic [AW-1:0] NEG4 = ~AW'(3);

  logic [AW-1:0] step, imm_ext, modv, sum;
  logic          imm_ok;

  always_comb begin
    case (req_size)
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
    imm_ext = {{(AW-IMM_W){req_imm[IMM_W-1]}}, req_imm};
    imm_ok  = (req_cls == CLS_PTR) || (imm_ext == AW'(2)) || (imm_ext == AW'(4))
              || (imm_ext == NEG2) || (imm_ext == NEG4);
    case (req_msrc)
      MSRC_INC: modv = step;
      MSRC_DEC: modv = AW'(0) - step;
      MSRC_IMM: modv = imm_ext;
      default:  modv = mreg_val;
    endcase
    sum      = base_val + modv;
    bad      = req_valid && (req_cls == CLS_IDX) && (req_msrc == MSRC_IMM) && !imm_ok;
    addr_nxt = (req_mode == MODE_POST) ? base_val : sum;
    upd_en   = req_valid && !bad && (req_mode == MODE_POST);
    upd_val  = sum;
  end

  p_auto_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_msrc == MSRC_INC)) |->
      ((upd_val - base_val == AW'(1)) || (upd_val - base_val == AW'(2)) || (upd_val - base_val == AW'(4))));
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit import agu_pkg::*; #(
  parameter int AW    = 32,
  parameter int NIDX  = 4,
  parameter int NPTR  = 8,
  parameter int IMM_W = 8,
  localparam int PTR_SW = $clog2(NPTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_cls,
  input  logic              req_mode,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_msrc,
  input  logic [PTR_SW-1:0] req_reg,
  input  logic [PTR_SW-1:0] req_mreg,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic              wr_en,
  input  logic [1:0]        wr_file,
  input  logic [PTR_SW-1:0] wr_sel,
  input  logic [AW-1:0]     wr_data,
  output logic [AW-1:0]     addr_o,
  output logic              addr_vld_o,
  output logic              err_o
);
  logic [AW-1:0] base_val, mreg_val, addr_nxt, upd_val;
  logic          upd_en, bad;
  logic          accept, vld_nxt, err_nxt;
  logic [AW-1:0] addr_q;
  logic          vld_q, err_q;

  agu_regfile #(.AW(AW), .NIDX(NIDX), .NPTR(NPTR)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_file(wr_file), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(upd_en), .upd_cls(req_cls), .upd_sel(req_reg), .upd_val(upd_val),
    .rd_cls(req_cls), .rd_base_sel(req_reg), .rd_mod_sel(req_mreg),
    .base_val(base_val), .mreg_val(mreg_val)
  );

  agu_calc #(.AW(AW), .IMM_W(IMM_W)) i_calc (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_cls(req_cls), .req_mode(req_mode),
    .req_size(req_size), .req_msrc(req_msrc), .req_imm(req_imm),
    .base_val(base_val), .mreg_val(mreg_val),
    .addr_nxt(addr_nxt), .upd_en(upd_en), .upd_val(upd_val), .bad(bad)
  );

  always_comb begin
    accept  = req_valid && !bad;
    vld_nxt = accept;
    err_nxt = bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (accept) addr_q <= addr_nxt;
      vld_q <= vld_nxt;
      err_q <= err_nxt;
    end
  end

  assign addr_o     = addr_q;
  assign addr_vld_o = vld_q;
  assign err_o      = err_q;

  p_vld_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld_o |-> $past(req_valid));
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_vld_o && err_o));
  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(req_valid && (req_cls == CLS_IDX) && (req_msrc == MSRC_IMM)));
  p_post_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld_o && ($past(req_mode) == MODE_POST)) |-> (addr_o == $past(base_val)));
  p_offs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && (req_mode == MODE_OFFS) && !wr_en)
     && (req_cls == $past(req_cls)) && (req_reg == $past(req_reg))) |-> (base_val == $past(base_val)));
endmodule

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_cls = 1'b0, req_mode = 1'b0;
  logic [1:0]  req_size = '0, req_msrc = '0;
  logic [2:0]  req_reg = '0, req_mreg = '0;
  logic [7:0]  req_imm = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_file = '0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] addr_o;
  logic        addr_vld_o, err_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  addr_gen_unit i_addr_gen_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cls(req_cls),
    .req_mode(req_mode), .req_size(req_size), .req_msrc(req_msrc),
    .req_reg(req_reg), .req_mreg(req_mreg), .req_imm(req_imm),
    .wr_en(wr_en), .wr_file(wr_file), .wr_sel(wr_sel), .wr_data(wr_data),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic cls, input logic mode, input logic [1:0] sz,
                         input logic [1:0] ms, input logic [2:0] rg, input logic [2:0] mr,
                         input logic [7:0] imm);
    req_valid = 1'b1; req_cls = cls; req_mode = mode; req_size = sz;
    req_msrc = ms; req_reg = rg; req_mreg = mr; req_imm = imm;
  endtask

  task automatic req(input logic cls, input logic mode, input logic [1:0] sz,
                     input logic [1:0] ms, input logic [2:0] rg, input logic [2:0] mr,
                     input logic [7:0] imm);
    @(negedge clk);
    set_req(cls, mode, sz, ms, rg, mr, imm);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] f, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_file = f; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek_p(input logic [2:0] s, output logic [31:0] v);
    req(1'b1, 1'b1, 2'd2, 2'd2, s, 3'd0, 8'd0);
    v = addr_o;
  endtask

  task automatic peek_i(input logic [2:0] s, output logic [31:0] v);
    req(1'b0, 1'b1, 2'd2, 2'd3, s, 3'd3, 8'd0);
    v = addr_o;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 vld after reset", {31'd0, addr_vld_o}, 32'd0);
    chk("R1 err after reset", {31'd0, err_o}, 32'd0);
    for (int k = 0; k < 8; k++) begin
      peek_p(3'(k), v);
      chk("R1 pointer reset", v, 32'd0);
    end
    peek_i(3'd0, v);
    chk("R1 index reset", v, 32'd0);
    @(negedge clk);
    chk("R2 vld drops with no request", {31'd0, addr_vld_o}, 32'd0);
  endtask

  task automatic t_post_ptr;
    logic [31:0] v;
    wr(2'd2, 3'd3, 32'h1000);
    req(1'b1, 1'b0, 2'd2, 2'd0, 3'd3, 3'd0, 8'd0);
    chk("R3 post addr", addr_o, 32'h1000);
    chk("R2 vld", {31'd0, addr_vld_o}, 32'd1);
    peek_p(3'd3, v); chk("R5 word step", v, 32'h1004);
    req(1'b1, 1'b0, 2'd0, 2'd0, 3'd3, 3'd0, 8'd0);
    chk("R3 byte post addr", addr_o, 32'h1004);
    peek_p(3'd3, v); chk("R5 byte step", v, 32'h1005);
    req(1'b1, 1'b0, 2'd1, 2'd1, 3'd3, 3'd0, 8'd0);
    peek_p(3'd3, v); chk("R5 half decrement", v, 32'h1003);
  endtask

  task automatic t_offset;
    logic [31:0] v;
    wr(2'd2, 3'd1, 32'h200);
    req(1'b1, 1'b1, 2'd2, 2'd2, 3'd1, 3'd0, 8'hF8);
    chk("R4 offset addr", addr_o, 32'h1F8);
    peek_p(3'd1, v); chk("R4 no writeback", v, 32'h200);
  endtask

  task automatic t_ptr_mod;
    logic [31:0] v;
    wr(2'd2, 3'd2, 32'h40);
    wr(2'd2, 3'd5, 32'h100);
    req(1'b1, 1'b0, 2'd2, 2'd3, 3'd5, 3'd2, 8'd0);
    chk("R7 reg-mod post addr", addr_o, 32'h100);
    peek_p(3'd5, v); chk("R7 pointer modifier", v, 32'h140);
    req(1'b1, 1'b1, 2'd2, 2'd2, 3'd5, 3'd0, 8'd100);
    chk("R7 wide immediate", addr_o, 32'h1A4);
    req(1'b1, 1'b1, 2'd2, 2'd2, 3'd5, 3'd0, 8'd3);
    chk("R7 odd imm accepted", {30'd0, err_o, addr_vld_o}, 32'd1);
  endtask

  task automatic t_index;
    logic [31:0] v;
    wr(2'd0, 3'd2, 32'h800);
    wr(2'd1, 3'd1, 32'h30);
    req(1'b0, 1'b0, 2'd2, 2'd3, 3'd2, 3'd1, 8'd0);
    chk("R6 index post addr", addr_o, 32'h800);
    peek_i(3'd2, v); chk("R6 modify reg applied", v, 32'h830);
    req(1'b0, 1'b0, 2'd2, 2'd2, 3'd2, 3'd0, 8'hFC);
    chk("R6 imm post addr", addr_o, 32'h830);
    peek_i(3'd2, v); chk("R6 imm -4", v, 32'h82C);
    req(1'b0, 1'b0, 2'd1, 2'd0, 3'd2, 3'd0, 8'd0);
    peek_i(3'd2, v); chk("R5 index half step", v, 32'h82E);
  endtask

  task automatic t_bad_imm;
    logic [31:0] v;
    req(1'b0, 1'b0, 2'd2, 2'd2, 3'd2, 3'd0, 8'd3);
    chk("R8 err strobe", {31'd0, err_o}, 32'd1);
    chk("R8 no vld", {31'd0, addr_vld_o}, 32'd0);
    peek_i(3'd2, v); chk("R8 no writeback", v, 32'h82E);
    req(1'b0, 1'b0, 2'd2, 2'd2, 3'd2, 3'd0, 8'd0);
    chk("R8 zero imm refused", {31'd0, err_o}, 32'd1);
    @(negedge clk);
    chk("R8 err one cycle", {31'd0, err_o}, 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(2'd2, 3'd0, 32'hFFFF_FFFE);
    req(1'b1, 1'b0, 2'd2, 2'd0, 3'd0, 3'd0, 8'd0);
    peek_p(3'd0, v); chk("R9 wrap up", v, 32'h2);
    req(1'b1, 1'b0, 2'd0, 2'd1, 3'd6, 3'd0, 8'd0);
    peek_p(3'd6, v); chk("R9 wrap down", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(2'd2, 3'd4, 32'h10);
    @(negedge clk);
    set_req(1'b1, 1'b0, 2'd2, 2'd0, 3'd4, 3'd0, 8'd0);
    wr_en = 1'b1; wr_file = 2'd2; wr_sel = 3'd4; wr_data = 32'h500;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    chk("R10 addr from old value", addr_o, 32'h10);
    peek_p(3'd4, v); chk("R10 software write wins", v, 32'h500);
  endtask

  task automatic t_b2b;
    logic [31:0] v;
    wr(2'd2, 3'd7, 32'h300);
    @(negedge clk);
    set_req(1'b1, 1'b0, 2'd2, 2'd0, 3'd7, 3'd0, 8'd0);
    @(negedge clk);
    chk("R11 first addr", addr_o, 32'h300);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 second addr", addr_o, 32'h304);
    peek_p(3'd7, v); chk("R11 chained writeback", v, 32'h308);
  endtask

  task automatic t_wfile;
    logic [31:0] v;
    wr(2'd3, 3'd0, 32'hDEAD_BEEF);
    peek_p(3'd0, v); chk("R12 file 3 leaves pointer", v, 32'h2);
    peek_i(3'd0, v); chk("R12 file 3 leaves index", v, 32'h0);
    wr(2'd1, 3'd0, 32'h8);
    req(1'b0, 1'b1, 2'd2, 2'd3, 3'd0, 3'd0, 8'd0);
    chk("R12 modify write seen", addr_o, 32'h8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_post_ptr;
    t_offset;
    t_ptr_mod;
    t_index;
    t_bad_imm;
    t_wrap;
    t_collide;
    t_b2b;
    t_wfile;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule